// File: doc/BRIEF.md
# Phase-Synchronized Up-Down PWM Timebase

This block generates two pulse-width-modulated outputs from one triangular carrier. The carrier comes from a counter that climbs from zero to a programmable period and then falls back to zero, so one carrier cycle lasts twice the period in clock cycles. Each output is driven high when the counter meets its compare value while rising, and driven low when it meets the same value while falling. The result is a pulse centred on the carrier peak.

Several instances can be chained to produce carriers with fixed or run-time adjustable phase offsets. A sync pulse on the input can make the counter jump to a programmed phase value and continue in a chosen direction. The sync output then either marks this instance's counter zero or repeats the incoming pulse, so the next instance in the chain can be aligned. The period and both compare values are written through a shadow copy, which takes effect only at counter zero. The phase and control fields take effect at once.

The counter is a two-state machine. In state `CNT_UP` the counter increments. The transition `UP_TURN` to `CNT_DOWN` is taken once the counter reaches the period. In state `CNT_DOWN` the counter decrements. The transition `DOWN_TURN` back to `CNT_UP` is taken at zero. A third transition, `SYNC_LOAD`, applies from either state: on an accepted sync pulse the counter takes the phase value and moves to the state named by the phase-direction bit.

Top module: `phased_pwm_core`

## Requirements
- R1: After reset the counter counts 0,1,…,P,P−1,…,1,0,1,… with P the active period. `dir_o` is 0 while rising and 1 while falling. The value P is reported with `dir_o`=0.
- R2: A write to compare A (address 1) or compare B (address 2) changes the active compare value only in the cycle after the counter shows zero. A cycle already in progress keeps its old compare value.
- R3: A write to the period (address 0) becomes active only in the cycle after the counter shows zero. The cycle in progress still peaks at the old period.
- R4: With control bit 0 (phase enable) set and bit 1 clear, a sync input high at a clock edge loads the phase (address 3) into the counter at that edge. Counting then continues upward.
- R5: With control bit 1 (phase direction) set, the counter counts downward right after a sync load.
- R6: With control bit 0 clear, the sync input has no effect on the counter.
- R7: A phase value above the active period is loaded as the active period.
- R8: `pwm_a` goes high on the edge after the counter shows compare A while rising. It goes low on the edge after the counter shows compare A while falling. Otherwise it holds its level.
- R9: `pwm_b` follows the rule of R8 using compare B.
- R10: A sync load that jumps over a compare value causes no output event for that crossing. The output holds its level until the next real match.
- R11: With control bit 2 clear, `sync_out` is high exactly while the counter shows zero.
- R12: With control bit 2 set, `sync_out` equals `sync_in` in the same cycle.
- R13: While reset is asserted the counter is 0, `dir_o` is 0 and both PWM outputs are 0. The control register (address 4) is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 period, 1 compare A, 2 compare B, 3 phase, 4 control |
| wr_data | input | W | Write data; control uses bits 2:0 |
| sync_in | input | 1 | Sync pulse from upstream instance |
| sync_out | output | 1 | Sync pulse to downstream instance |
| cnt_o | output | W | Current counter value |
| dir_o | output | 1 | 1 while counting down |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The assertions assume that the active period is at least 2 and that every compare value lies strictly between zero and the period. These are the only settings for which each carrier cycle has exactly one rising and one falling match per channel. The stimulus keeps the period at 10 or 12 and the compare values between 3 and 7. The stimulus starts each test phase with a sync load to phase zero, which puts the shadow registers into use at a known edge. Register writes are never issued in the same cycle as a counter zero.

// File: rtl/phased_pwm_pkg.sv
package phased_pwm_pkg;

    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_state_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_PERIOD = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CMP0   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_PHASE  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd4;

    typedef struct packed {
        logic sync_pass;
        logic phs_down;
        logic phs_en;
    } ctrl_t;

endpackage

// File: rtl/ppwm_regs.sv
module ppwm_regs
    import phased_pwm_pkg::*;
#(
    parameter int W            = 16,
    parameter int NCH          = 2,
    parameter int RESET_PERIOD = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [W-1:0]            wr_data,
    input  logic                    at_zero,
    output logic [W-1:0]            prd_act,
    output logic [NCH-1:0][W-1:0]   cmp_act,
    output logic [W-1:0]            phase,
    output ctrl_t                   ctrl
);
    localparam logic [W-1:0] PRD_RST = W'(RESET_PERIOD);

    logic [W-1:0] prd_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_sh  <= PRD_RST;
            prd_act <= PRD_RST;
            phase   <= '0;
            ctrl    <= '0;
        end else begin
            if (wr_en && wr_addr == ADR_PERIOD) prd_sh <= wr_data;
            if (wr_en && wr_addr == ADR_PHASE)  phase  <= wr_data;
            if (wr_en && wr_addr == ADR_CTRL)   ctrl   <= ctrl_t'(wr_data[2:0]);
            if (at_zero)                        prd_act <= prd_sh;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        localparam logic [ADDR_W-1:0] MY_ADR = ADR_CMP0 + ADDR_W'(g);
        logic [W-1:0] cmp_sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_sh     <= '0;
                cmp_act[g] <= '0;
            end else begin
                if (wr_en && wr_addr == MY_ADR) cmp_sh <= wr_data;
                if (at_zero)                    cmp_act[g] <= cmp_sh;
            end
        end
    end

endmodule

// File: rtl/ppwm_counter.sv
module ppwm_counter
    import phased_pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] prd,
    input  logic [W-1:0] phase,
    input  logic         phs_en,
    input  logic         phs_down,
    input  logic         sync_in,
    output logic [W-1:0] cnt,
    output logic         dir_down,
    output logic         at_zero
);
    cnt_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] phase_lim;

    always_comb begin
        phase_lim = (phase > prd) ? prd : phase;
        state_d   = state_q;
        cnt_d     = cnt_q;
        unique case (state_q)
            CNT_UP: begin
                if (cnt_q >= prd) begin         // UP_TURN
                    state_d = CNT_DOWN;
                    cnt_d   = cnt_q - 1'b1;
                end else begin
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            CNT_DOWN: begin
                if (cnt_q == '0) begin          // DOWN_TURN
                    state_d = CNT_UP;
                    cnt_d   = W'(1);
                end else begin
                    cnt_d   = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = CNT_UP;
                cnt_d   = '0;
            end
        endcase
        if (sync_in && phs_en) begin            // SYNC_LOAD
            cnt_d   = phase_lim;
            state_d = phs_down ? CNT_DOWN : CNT_UP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_UP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        cnt      = cnt_q;
        dir_down = (state_q == CNT_DOWN);
        at_zero  = (cnt_q == '0);
    end

endmodule

// File: rtl/ppwm_action.sv
module ppwm_action #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic         dir_down,
    input  logic [W-1:0] cmp,
    output logic         pwm
);
    logic hit;

    always_comb hit = (cnt == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pwm <= 1'b0;
        else if (hit && !dir_down) pwm <= 1'b1;
        else if (hit &&  dir_down) pwm <= 1'b0;
    end

endmodule

// File: rtl/phased_pwm_core.sv
module phased_pwm_core
    import phased_pwm_pkg::*;
#(
    parameter int W            = 16,
    parameter int RESET_PERIOD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              sync_in,
    output logic              sync_out,
    output logic [W-1:0]      cnt_o,
    output logic              dir_o,
    output logic              pwm_a,
    output logic              pwm_b
);
    localparam int NCH = 2;

    logic [W-1:0]          prd_act;
    logic [NCH-1:0][W-1:0] cmp_act;
    logic [W-1:0]          phase;
    ctrl_t                 ctrl;
    logic                  at_zero;
    logic [NCH-1:0]        pwm_v;

    ppwm_regs #(.W(W), .NCH(NCH), .RESET_PERIOD(RESET_PERIOD)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .at_zero (at_zero),
        .prd_act (prd_act),
        .cmp_act (cmp_act),
        .phase   (phase),
        .ctrl    (ctrl)
    );

    ppwm_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .prd      (prd_act),
        .phase    (phase),
        .phs_en   (ctrl.phs_en),
        .phs_down (ctrl.phs_down),
        .sync_in  (sync_in),
        .cnt      (cnt_o),
        .dir_down (dir_o),
        .at_zero  (at_zero)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ppwm_action #(.W(W)) u_act (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt_o),
            .dir_down (dir_o),
            .cmp      (cmp_act[g]),
            .pwm      (pwm_v[g])
        );
    end

    always_comb begin
        pwm_a    = pwm_v[0];
        pwm_b    = pwm_v[1];
        sync_out = ctrl.sync_pass ? sync_in : at_zero;
    end

endmodule

// File: rtl/phased_pwm_chk.sv
module phased_pwm_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt,
    input logic         dir,
    input logic [W-1:0] prd,
    input logic [W-1:0] cmpa,
    input logic [W-1:0] cmpb,
    input logic [W-1:0] phase,
    input logic         phs_en,
    input logic         phs_down,
    input logic         sync_in,
    input logic         pwm_a,
    input logic         pwm_b
);
    // R1
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sync_in && phs_en)) |->
        ((cnt == W'($past(cnt) + 1'b1)) || (cnt == W'($past(cnt) - 1'b1))));

    // R4 R5 R7
    sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sync_in && phs_en)) |->
        (cnt == ($past(phase) > $past(prd) ? $past(prd) : $past(phase)))
        && (dir == $past(phs_down)));

    // R2
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!$stable(cmpa) || !$stable(cmpb))) |-> $past(cnt == '0));

    // R3
    prd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(prd)) |-> $past(cnt == '0));

    // R8
    a_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(pwm_a)) |-> $past(cnt == cmpa && !dir));

    // R8
    a_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(pwm_a)) |-> $past(cnt == cmpa && dir));

    // R9
    b_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(pwm_b)) |-> $past(cnt == cmpb && !dir));

    // R9
    b_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(pwm_b)) |-> $past(cnt == cmpb && dir));

endmodule

bind phased_pwm_core phased_pwm_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt_o),
    .dir      (dir_o),
    .prd      (prd_act),
    .cmpa     (cmp_act[0]),
    .cmpb     (cmp_act[1]),
    .phase    (phase),
    .phs_en   (ctrl.phs_en),
    .phs_down (ctrl.phs_down),
    .sync_in  (sync_in),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b)
);

// File: tb/tb_phased_pwm_core.sv
module tb_phased_pwm_core;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         sync_in = 1'b0;
    logic         sync_out, dir_o, pwm_a, pwm_b;
    logic [W-1:0] cnt_o;

    phased_pwm_core #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_in(sync_in), .sync_out(sync_out),
        .cnt_o(cnt_o), .dir_o(dir_o), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef enum {K_CNT, K_DIR, K_A, K_B, K_SO} kind_e;
    typedef struct {
        int    at;
        kind_e k;
        int    v;
        string tag;
    } item_t;
    item_t sb[$];

    int checks = 0;
    int fails  = 0;

    function automatic void check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    function automatic int sample(kind_e k);
        case (k)
            K_CNT:   return int'(cnt_o);
            K_DIR:   return int'(dir_o);
            K_A:     return int'(pwm_a);
            K_B:     return int'(pwm_b);
            default: return int'(sync_out);
        endcase
    endfunction

    task automatic push(int at, kind_e k, int v, string tag);
        item_t it;
        it.at = at; it.k = k; it.v = v; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: pops items due at this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                check(sb[i].tag, sample(sb[i].k), sb[i].v);
                sb.delete(i);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic goto(int e);
        while (cyc < e) step();
    endtask

    task automatic wr(logic [2:0] a, int d);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic sync_pulse(output int k);
        sync_in = 1'b1;
        step();
        sync_in = 1'b0;
        k = cyc;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0 pending", sb.size());
        finish_run();
    end

    initial begin
        int k;
        step(); step(); step();
        // R13 reset state
        check("R13 cnt in reset", int'(cnt_o), 0);
        check("R13 dir in reset", int'(dir_o), 0);
        check("R13 pwm_a in reset", int'(pwm_a), 0);
        check("R13 pwm_b in reset", int'(pwm_b), 0);
        rst_n = 1'b1;
        step();

        // base setup: P=10, CA=3, CB=7, phase 0, phase enable, zero sync
        wr(3'd0, 10); wr(3'd1, 3); wr(3'd2, 7); wr(3'd3, 0); wr(3'd4, 1);
        step();
        sync_pulse(k);
        push(k+5,  K_CNT, 5,  "R1 rising");
        push(k+10, K_CNT, 10, "R1 peak");
        push(k+10, K_DIR, 0,  "R1 dir at peak");
        push(k+11, K_CNT, 9,  "R1 falling");
        push(k+11, K_DIR, 1,  "R1 dir falling");
        push(k+15, K_CNT, 5,  "R1 falling mid");
        push(k+20, K_CNT, 0,  "R1 bottom");
        push(k+21, K_CNT, 1,  "R1 restart");
        push(k+4,  K_A, 1,    "R8 set on up match");
        push(k+17, K_A, 1,    "R8 held");
        push(k+18, K_A, 0,    "R8 clear on down match");
        push(k+8,  K_B, 1,    "R9 set on up match");
        push(k+13, K_B, 1,    "R9 held");
        push(k+14, K_B, 0,    "R9 clear on down match");
        push(k+19, K_SO, 0,   "R11 low off zero");
        push(k+20, K_SO, 1,   "R11 high at zero");
        push(k+21, K_SO, 0,   "R11 low after zero");
        // shadow writes mid-cycle
        goto(k+22);
        wr(3'd1, 5);
        wr(3'd0, 12);
        push(k+30, K_CNT, 10, "R3 old period peak");
        push(k+38, K_A, 0,    "R2 old compare clear");
        push(k+37, K_A, 1,    "R2 old compare held");
        push(k+46, K_A, 1,    "R2 new compare set");
        push(k+45, K_A, 0,    "R2 new compare not yet");
        push(k+52, K_CNT, 12, "R3 new period peak");
        push(k+53, K_CNT, 11, "R3 new period turn");
        push(k+60, K_A, 0,    "R2 new compare clear");
        goto(k+61);
        wr(3'd0, 10); wr(3'd1, 3);
        goto(k+70);

        // R4 load and count up
        wr(3'd3, 4); wr(3'd4, 1);
        sync_pulse(k);
        push(k,   K_CNT, 4, "R4 loaded phase");
        push(k+1, K_CNT, 5, "R4 counts up");
        push(k+1, K_DIR, 0, "R4 dir up");
        goto(k+3);
        // R5 load and count down
        wr(3'd3, 6); wr(3'd4, 3);
        sync_pulse(k);
        push(k,   K_CNT, 6, "R5 loaded phase");
        push(k+1, K_CNT, 5, "R5 counts down");
        push(k+1, K_DIR, 1, "R5 dir down");
        goto(k+3);
        // R7 clamp
        wr(3'd3, 50);
        sync_pulse(k);
        push(k,   K_CNT, 10, "R7 clamped to period");
        push(k+1, K_CNT, 9,  "R7 after clamp");
        goto(k+3);

        // R6 phase disabled ignores sync
        wr(3'd3, 0); wr(3'd4, 1);
        sync_pulse(k);
        wr(3'd4, 0);
        wr(3'd3, 6);
        goto(k+4);
        sync_pulse(k);
        push(k,   K_CNT, 5, "R6 sync ignored");
        push(k+1, K_CNT, 6, "R6 keeps counting");
        goto(k+3);

        // R12 pass-through
        wr(3'd3, 0); wr(3'd4, 5);
        sync_in = 1'b1;
        push(cyc, K_SO, 1, "R12 passes high");
        step();
        sync_in = 1'b0;
        push(cyc, K_CNT, 0, "R12 load with pass-through");
        push(cyc, K_SO, 0,  "R12 no zero pulse");
        step(); step();

        // R10 skipped compare crossing
        wr(3'd4, 1);
        sync_pulse(k);
        wr(3'd3, 8);
        goto(k+18);
        push(k+18, K_A, 0, "R10 cleared before jump");
        step();
        sync_pulse(k);
        push(k,    K_CNT, 8, "R10 jumped");
        push(k+2,  K_A, 0,   "R10 no set on skipped crossing");
        push(k+8,  K_B, 0,   "R10 no set on skipped B crossing");
        push(k+14, K_A, 0,   "R10 held until real match");
        push(k+16, K_A, 1,   "R10 set on next real match");
        goto(k+18);

        step(); step();
        for (int i = 0; i < sb.size(); i++) begin
            fails++;
            $display("FAIL %s actual=unsampled expected=%0d", sb[i].tag, sb[i].v);
        end
        finish_run();
    end

endmodule